// File: doc/BRIEF.md
# Interleaved Slice Result Collector

An interleaved converter built from eighteen slow slices needs one point where their results merge back into a single stream at the full clock rate. This block is that point. Each slice puts a 13-bit raw result on its own bus, with a strobe, during its transfer cycle. A rotating slot pointer picks the slice whose turn it is on every rising clock edge. The pointer starts at a fixed slot when reset is released, so a given slice is always read in the same slot of the 18-cycle frame.

The selected raw value carries an offset margin. It is shifted down by that offset and clamped into a 12-bit straight-binary code. An out-of-range flag is raised whenever the clamp acts. A short register chain then pads the path, so that every output word appears a fixed number of clocks after its sample was taken.

The output is a valid-qualified stream with no ready input. The slices cannot be stalled, so the consumer must take every word in the cycle where `code_vld` is high, and no word waits for it. When `code_vld` is low, the code and flag outputs hold the last delivered word.

Top module: `rr_result_mux`

## Requirements
- R1: While `rst_n` is low, `code_vld`, `oor_out` and `code_out` are all 0.
- R2: Counting rising edges from the first one with `rst_n` high as edge 0, the block reads slice `(e - 12) mod 18` at edge `e`. Buses of slices not being read have no effect on the outputs.
- R3: For a raw value `x` with 2048 <= x <= 6143, the output is `code_out = x - 2048` with `oor_out = 0`. For example, x = 4096 gives 0x800 and x = 2048 gives 0x000.
- R4: For a raw value `x` > 6143, the output is `code_out = 0xFFF` with `oor_out = 1`. An `oor_out` of 1 is only ever seen with a code of all zeros or all ones.
- R5: For a raw value `x` < 2048, the output is `code_out = 0x000` with `oor_out = 1`. The value x = 6143 gives 0xFFF with `oor_out = 0`.
- R6: Slice `i mod 18` samples in cycle `i`. Its word is read at edge `i + 12` and is visible on the outputs right after edge `i + 14`, a fixed latency of 14 clocks.
- R7: After reset release, `code_vld` stays low until a strobed word has crossed the capture stage and both pad stages. It is low after edges 0 and 1 and can first be high after edge 2.
- R8: When the slice being read has its strobe low, `code_vld` is low for that word's output cycle, and `code_out` and `oor_out` keep the previously delivered word. The rotation pointer advances by one per edge and wraps from 17 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; aligns the slot pointer |
| slice_res | input | 234 | Raw results, slice k in bits [13k+12:13k] |
| slice_vld | input | 18 | Result strobe of each slice, bit k for slice k |
| code_out | output | 12 | Straight-binary output code |
| oor_out | output | 1 | Out-of-range flag of the delivered word |
| code_vld | output | 1 | The delivered word is valid this cycle |

## Verification
The assertions check the following on every cycle:
- the pointer steps by one and wraps after slot 17;
- a raised range flag only ever appears with a rail code;
- code and flag stay frozen while `code_vld` is low;
- the valid output stays quiet through the first two cycles after reset release.

Only the bench's scenarios can show the rest:
- the absolute slot alignment and the 14-clock latency, tracked from a known reset edge;
- the exact arithmetic of the offset removal at each clamp boundary;
- that an unstrobed slot leaves the previous word in place rather than some other value.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  localparam int RAW_W  = 13;
  localparam int CODE_W = 12;

  typedef struct packed {
    logic              vld;
    logic              oor;
    logic [CODE_W-1:0] code;
  } out_word_t;
endpackage

// File: rtl/rrm_slot_ptr.sv
module rrm_slot_ptr #(
  parameter int N_SLOTS = 18,
  parameter int START   = 0,
  localparam int PTR_W  = $clog2(N_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(N_SLOTS - 1);
  localparam logic [PTR_W-1:0] FIRST = PTR_W'(START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= FIRST;
    end else if (ptr == LAST) begin
      ptr <= '0;
    end else begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/rrm_range_map.sv
module rrm_range_map
  import rrm_pkg::*;
#(
  parameter int OFFSET = 2048
) (
  input  logic [RAW_W-1:0]  raw,
  output logic [CODE_W-1:0] code,
  output logic              oor
);
  localparam int DW = RAW_W + 2;
  localparam logic signed [DW-1:0] OFF_V = DW'(OFFSET);
  localparam logic signed [DW-1:0] TOP_V = DW'((1 << CODE_W) - 1);

  logic signed [DW-1:0] shifted;

  always_comb begin
    shifted = $signed({2'b00, raw}) - OFF_V;
    if (shifted < 0) begin
      code = '0;
      oor  = 1'b1;
    end else if (shifted > TOP_V) begin
      code = '1;
      oor  = 1'b1;
    end else begin
      code = shifted[CODE_W-1:0];
      oor  = 1'b0;
    end
  end
endmodule

// File: rtl/rrm_delay.sv
module rrm_delay
  import rrm_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  out_word_t din,
  output out_word_t dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_chain
      out_word_t stage [DEPTH];
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        out_word_t prev;
        if (s == 0) begin : g_head
          assign prev = din;
        end else begin : g_link
          assign prev = stage[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stage[s] <= '0;
          end else begin
            stage[s].vld <= prev.vld;
            if (prev.vld) begin
              stage[s].oor  <= prev.oor;
              stage[s].code <= prev.code;
            end
          end
        end
      end
      assign dout = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/rr_result_mux.sv
module rr_result_mux
  import rrm_pkg::*;
#(
  parameter int N_SLICES = 18,
  parameter int XFER_LAG = 12,
  parameter int LATENCY  = 14,
  parameter int OFFSET   = 2048
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SLICES*RAW_W-1:0] slice_res,
  input  logic [N_SLICES-1:0]       slice_vld,
  output logic [CODE_W-1:0]         code_out,
  output logic                      oor_out,
  output logic                      code_vld
);
  localparam int PTR_W = $clog2(N_SLICES);
  localparam int PAD   = LATENCY - XFER_LAG;
  localparam int PTR0  = (N_SLICES - (XFER_LAG % N_SLICES)) % N_SLICES;

  logic [PTR_W-1:0]  ptr;
  logic [RAW_W-1:0]  res_arr [N_SLICES];
  logic [RAW_W-1:0]  sel_raw;
  logic              sel_vld;
  logic [CODE_W-1:0] map_code;
  logic              map_oor;
  out_word_t         cap_w;
  out_word_t         out_w;
  logic              cap_vld;

  for (genvar g = 0; g < N_SLICES; g++) begin : g_unpack
    assign res_arr[g] = slice_res[g*RAW_W +: RAW_W];
  end

  rrm_slot_ptr #(.N_SLOTS(N_SLICES), .START(PTR0)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ptr   (ptr)
  );

  always_comb begin
    sel_raw = res_arr[ptr];
    sel_vld = slice_vld[ptr];
  end

  rrm_range_map #(.OFFSET(OFFSET)) u_map (
    .raw  (sel_raw),
    .code (map_code),
    .oor  (map_oor)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_w <= '0;
    end else begin
      cap_w.vld <= sel_vld;
      if (sel_vld) begin
        cap_w.code <= map_code;
        cap_w.oor  <= map_oor;
      end
    end
  end

  assign cap_vld = cap_w.vld;

  rrm_delay #(.DEPTH(PAD)) u_pad (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cap_w),
    .dout  (out_w)
  );

  assign code_out = out_w.code;
  assign oor_out  = out_w.oor;
  assign code_vld = out_w.vld;
endmodule

// File: rtl/rrm_checker.sv
module rrm_checker #(
  parameter int N     = 18,
  parameter int PAD   = 2,
  parameter int PTR_W = 5,
  parameter int CW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTR_W-1:0] ptr,
  input logic [CW-1:0]    code_out,
  input logic             oor_out,
  input logic             code_vld
);
  int unsigned since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 0;
    end else if (since_rst <= PAD) begin
      since_rst <= since_rst + 1;
    end
  end

  // R2 / R8: pointer advances by one
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != PTR_W'(N - 1)) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  // R2 / R8: pointer wraps to slot 0
  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == PTR_W'(N - 1)) |=> (ptr == '0));

  // R4 and R5: a raised flag sits on a rail code
  assert_flag_rail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oor_out |-> (code_out == '0 || code_out == '1));

  // R8: idle slots freeze the delivered word
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !code_vld |-> ($stable(code_out) && $stable(oor_out)));

  // R7: valid quiet while the pipeline fills
  assert_vld_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst <= PAD) |-> !code_vld);
endmodule

bind rr_result_mux rrm_checker #(
  .N     (N_SLICES),
  .PAD   (PAD),
  .PTR_W (PTR_W),
  .CW    (rrm_pkg::CODE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ptr      (ptr),
  .code_out (code_out),
  .oor_out  (oor_out),
  .code_vld (code_vld)
);

// File: tb/sim_rr_result_mux.sv
`timescale 1ns/1ps
module sim_rr_result_mux;
  localparam int NS = 18;
  localparam int RW = 13;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS*RW-1:0] slice_res;
  logic [NS-1:0]   slice_vld = '0;
  logic [11:0]     code_out;
  logic            oor_out;
  logic            code_vld;
  logic [RW-1:0]   val [NS];

  int n_chk  = 0;
  int n_fail = 0;
  int ecnt   = -1;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecnt <= -1;
    else        ecnt <= ecnt + 1;
  end

  always_comb begin
    for (int k = 0; k < NS; k++) slice_res[k*RW +: RW] = val[k];
  end

  rr_result_mux u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .slice_res (slice_res),
    .slice_vld (slice_vld),
    .code_out  (code_out),
    .oor_out   (oor_out),
    .code_vld  (code_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual=%0h expected=%0h", req, ecnt, act, exp);
    end
  endtask

  // Slice whose sample is on the outputs after edge m (R6: 14 clocks).
  function automatic int slot_of(input int m);
    int i = m - 14;
    return ((i % NS) + NS) % NS;
  endfunction

  // Expected {oor, code} from R3, R4, R5.
  function automatic logic [12:0] exp_word(input int x);
    if (x < 2048)       return {1'b1, 12'h000};
    else if (x > 6143)  return {1'b1, 12'hFFF};
    else                return {1'b0, 12'(x - 2048)};
  endfunction

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    for (int k = 0; k < NS; k++) val[k] = 13'(3000 + k);
    slice_vld = '1;
    wait_cycles(3);
    chk(code_vld == 1'b0, "R1 vld", int'(code_vld), 0);
    chk(oor_out == 1'b0, "R1 oor", int'(oor_out), 0);
    chk(code_out == 12'h000, "R1 code", int'(code_out), 0);
  endtask

  task automatic t_startup_valid;
    rst_n = 1'b1;
    @(negedge clk);
    chk(code_vld == 1'b0, "R7 edge0", int'(code_vld), 0);
    @(negedge clk);
    chk(code_vld == 1'b0, "R7 edge1", int'(code_vld), 0);
    @(negedge clk);
    chk(code_vld == 1'b1, "R7 edge2", int'(code_vld), 1);
  endtask

  task automatic t_rotation;
    for (int k = 0; k < NS; k++) val[k] = 13'(2048 + 100 * k + 1);
    slice_vld = '1;
    wait_cycles(22);
    for (int c = 0; c < NS; c++) begin
      int s = slot_of(ecnt);
      chk(code_out == 12'(100 * s + 1), "R2/R6 rotation", int'(code_out), 100 * s + 1);
      chk(code_vld == 1'b1, "R2 vld", int'(code_vld), 1);
      @(negedge clk);
    end
  endtask

  task automatic t_pulse;
    for (int k = 0; k < NS; k++) val[k] = 13'(2500 + k);
    slice_vld = '0;
    slice_vld[5] = 1'b1;
    wait_cycles(22);
    for (int c = 0; c < NS; c++) begin
      bit hit = (slot_of(ecnt) == 5);
      chk(code_vld == hit, "R6 latency", int'(code_vld), int'(hit));
      chk(code_out == 12'(2500 + 5 - 2048), "R6 value", int'(code_out), 457);
      @(negedge clk);
    end
  endtask

  task automatic t_codes;
    for (int k = 0; k < NS; k++) val[k] = 13'(3000);
    val[0] = 13'(4096);  val[1] = 13'(2048); val[2] = 13'(6143);
    val[3] = 13'(6144);  val[4] = 13'(2047); val[5] = 13'(0);
    val[6] = 13'(8191);  val[7] = 13'(2049);
    slice_vld = '1;
    wait_cycles(22);
    for (int c = 0; c < NS; c++) begin
      int s = slot_of(ecnt);
      logic [12:0] e = exp_word(int'(val[s]));
      string rq = (e[12] && e[11:0] == 12'hFFF) ? "R4 high clamp" :
                  (e[12]) ? "R5 low clamp" : "R3 straight binary";
      chk({oor_out, code_out} == e, rq, int'({oor_out, code_out}), int'(e));
      @(negedge clk);
    end
  endtask

  task automatic t_hold;
    for (int k = 0; k < NS; k++) begin
      val[k] = (k % 2 == 0) ? 13'(2048 + 37 * k + 5) : 13'(7000);
      slice_vld[k] = (k % 2 == 0);
    end
    wait_cycles(22);
    for (int c = 0; c < NS; c++) begin
      int s = slot_of(ecnt);
      int src = (s % 2 == 0) ? s : s - 1;
      logic [12:0] e = exp_word(int'(val[src]));
      chk(code_vld == (s % 2 == 0), "R8 vld", int'(code_vld), int'(s % 2 == 0));
      chk({oor_out, code_out} == e, "R8 hold", int'({oor_out, code_out}), int'(e));
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NS; k++) val[k] = '0;
    @(negedge clk);
    t_reset_state;
    t_startup_valid;
    t_rotation;
    t_pulse;
    t_codes;
    t_hold;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule